// File: doc/BRIEF.md
# Split Multi-Drop Express Channel

This block is a bypass link laid along one row or column of a mesh. It touches every router position on that line. A flit that is accepted on the link reaches its destination position in one hop and skips the routers in between. Each active segment of the link has exactly one configured source position. No other position can drive that segment, so senders need no arbitration and a transfer needs no request or grant phase. The source may sit anywhere in its segment and may send toward positions on either side of it.

A split control divides the link at a chosen point into a lower segment and an upper segment. Each segment has its own source, and the two segments can carry one transfer each in the same cycle. A change of source or split point is requested with a configuration handshake. The block first stops accepting new flits. It then waits until no flit is in flight on either segment, latches the new settings and acknowledges the change with a single-cycle pulse.

Top module: `mdx_channel`

## Requirements
- R1: After reset, no delivery or error is signalled, `drained` is 1, `cfg_done` is 0, and the link is unsplit with position 0 as its only source.
- R2: Only the configured source of a segment can inject. `inj_valid` at any other position has no effect on deliveries or errors.
- R3: A flit accepted at a clock edge is shown at the next edge on `dlv_valid[dest]` only, for one cycle, with its data unchanged at `dlv_data[dest*DATA_W +: DATA_W]`. Distance does not change this timing.
- R4: A source may send to positions below it or above it in its segment.
- R5: With split enabled and split point k, the lower segment holds positions 0..k and the upper segment holds positions k+1..N_POS-1. With split disabled, one segment holds all positions. With k = N_POS-1, the upper segment is empty.
- R6: With split enabled, both segments can deliver in the same cycle, to different positions.
- R7: A flit whose 3-bit destination lies outside its source's segment, or equals the source position, is dropped. `inj_err[src]` pulses for one cycle at the next edge.
- R8: A `cfg_req` sampled while the block is idle captures the four `cfg_*` inputs. No flit is accepted from the following edge on. `cfg_done` pulses for one cycle once both segments are empty. The captured settings govern injection from the cycle in which `cfg_done` is high.
- R9: `drained` is 1 exactly when no accepted flit is still waiting to be delivered.
- R10: A configured source whose position lies outside its own segment leaves that segment idle. It produces no delivery and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inj_valid | input | N_POS | Per-position flit offer |
| inj_dest | input | N_POS*3 | Per-position destination position |
| inj_data | input | N_POS*DATA_W | Per-position flit payload |
| cfg_req | input | 1 | Request to apply new settings |
| cfg_split | input | 1 | Requested split enable |
| cfg_point | input | 3 | Requested split point (last position of lower segment) |
| cfg_src_lo | input | 3 | Requested source of lower (or only) segment |
| cfg_src_hi | input | 3 | Requested source of upper segment |
| cfg_done | output | 1 | One-cycle acknowledge of applied settings |
| drained | output | 1 | No flit in flight on either segment |
| dlv_valid | output | N_POS | Per-position delivery strobe |
| dlv_data | output | N_POS*DATA_W | Per-position delivered payload |
| inj_err | output | N_POS | Per-position rejected-flit pulse |

## Verification
The assertions check the following on every cycle:
- an accepted flit always reaches the segment output stage at the next edge;
- nothing is accepted while a reconfiguration is pending;
- an accepted flit always comes from the active source;
- no more than two positions receive in one cycle;
- `cfg_done` is a lone pulse seen only while drained.

The directed scenarios show what a property cannot:
- segment membership for particular split points;
- delivery in both directions;
- the exact error position;
- that an old source is shut out and a new one admitted after the handshake.

// File: rtl/mdx_pkg.sv
// Shared definitions for the split multi-drop express channel.
package mdx_pkg;
    // Reconfiguration controller state
    typedef enum logic {
        MDX_RUN   = 1'b0,
        MDX_DRAIN = 1'b1
    } mdx_state_e;
endpackage

// File: rtl/mdx_cfg_ctrl.sv
// mdx_cfg_ctrl: holds the active settings, tracks the flits in flight per
// segment and runs the drain-then-commit handshake.
// Assumes the acceptance and delivery strobes of each segment come from
// mdx_segment. A request seen while a drain is pending is ignored.
module mdx_cfg_ctrl
    import mdx_pkg::*;
#(
    parameter int PW = 3,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_req,
    input  logic          req_split,
    input  logic [PW-1:0] req_point,
    input  logic [PW-1:0] req_src_lo,
    input  logic [PW-1:0] req_src_hi,
    input  logic          acc_a,
    input  logic          dlv_a,
    input  logic          acc_b,
    input  logic          dlv_b,
    output logic          run,
    output logic          drained,
    output logic          cfg_done,
    output logic          act_split,
    output logic [PW-1:0] act_point,
    output logic [PW-1:0] act_src_lo,
    output logic [PW-1:0] act_src_hi
);
    mdx_state_e    state;
    logic [CW-1:0] cnt_a, cnt_b;
    logic          pend_split;
    logic [PW-1:0] pend_point, pend_src_lo, pend_src_hi;

    // In-flight counters: up on acceptance, down on delivery
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_a <= '0;
            cnt_b <= '0;
        end else begin
            cnt_a <= cnt_a + CW'(acc_a) - CW'(dlv_a);
            cnt_b <= cnt_b + CW'(acc_b) - CW'(dlv_b);
        end
    end

    // Handshake: capture request, wait for empty, commit, pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= MDX_RUN;
            cfg_done    <= 1'b0;
            pend_split  <= 1'b0;
            pend_point  <= '0;
            pend_src_lo <= '0;
            pend_src_hi <= '0;
            act_split   <= 1'b0;
            act_point   <= '0;
            act_src_lo  <= '0;
            act_src_hi  <= '0;
        end else begin
            cfg_done <= 1'b0;
            case (state)
                MDX_RUN: begin
                    if (cfg_req) begin
                        pend_split  <= req_split;
                        pend_point  <= req_point;
                        pend_src_lo <= req_src_lo;
                        pend_src_hi <= req_src_hi;
                        state       <= MDX_DRAIN;
                    end
                end
                default: begin
                    if (cnt_a == '0 && cnt_b == '0) begin
                        act_split  <= pend_split;
                        act_point  <= pend_point;
                        act_src_lo <= pend_src_lo;
                        act_src_hi <= pend_src_hi;
                        cfg_done   <= 1'b1;
                        state      <= MDX_RUN;
                    end
                end
            endcase
        end
    end

    // Status decode
    always_comb begin
        run     = (state == MDX_RUN);
        drained = (cnt_a == '0) && (cnt_b == '0);
    end
endmodule

// File: rtl/mdx_segment.sv
// mdx_segment: one segment of the channel. It picks the flit offered at the
// configured source, checks the destination against the segment bounds and
// registers either a delivery or an error pulse.
// Assumes N <= 2**PW. UPPER selects the segment above the split point.
module mdx_segment #(
    parameter int N     = 8,
    parameter int PW    = 3,
    parameter int DW    = 32,
    parameter bit UPPER = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          split,
    input  logic [PW-1:0] point,
    input  logic [PW-1:0] src,
    input  logic [N-1:0]  inj_valid,
    input  logic [N*PW-1:0] inj_dest,
    input  logic [N*DW-1:0] inj_data,
    output logic          accept,
    output logic          q_vld,
    output logic [PW-1:0] q_dest,
    output logic [DW-1:0] q_data,
    output logic          err_vld,
    output logic [PW-1:0] err_pos
);
    localparam logic [PW:0] LAST = (PW+1)'(N - 1);

    logic [PW:0]   lo, hi;
    logic          present, src_in, dest_ok, fire;
    logic [PW-1:0] sel_dest;
    logic [DW-1:0] sel_data;

    // Segment bounds from the split settings
    generate
        if (UPPER) begin : g_upper
            always_comb begin
                lo      = {1'b0, point} + 1'b1;
                hi      = LAST;
                present = split && ({1'b0, point} < LAST);
            end
        end else begin : g_lower
            always_comb begin
                lo      = '0;
                hi      = split ? {1'b0, point} : LAST;
                present = 1'b1;
            end
        end
    endgenerate

    // Source selection and destination check
    always_comb begin
        src_in   = present && ({1'b0, src} >= lo) && ({1'b0, src} <= hi);
        sel_dest = inj_dest[src*PW +: PW];
        sel_data = inj_data[src*DW +: DW];
        fire     = run && src_in && inj_valid[src];
        dest_ok  = ({1'b0, sel_dest} >= lo) && ({1'b0, sel_dest} <= hi)
                   && (sel_dest != src);
        accept   = fire && dest_ok;
    end

    // One-cycle traversal stage and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld   <= 1'b0;
            q_dest  <= '0;
            q_data  <= '0;
            err_vld <= 1'b0;
            err_pos <= '0;
        end else begin
            q_vld   <= accept;
            err_vld <= fire && !dest_ok;
            err_pos <= src;
            if (accept) begin
                q_dest <= sel_dest;
                q_data <= sel_data;
            end
        end
    end
endmodule

// File: rtl/mdx_drop_fanout.sv
// mdx_drop_fanout: fans the two segment output stages out to the
// per-position delivery and error ports. The segments never overlap, so at
// most one of them addresses a given position.
module mdx_drop_fanout #(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int DW = 32
) (
    input  logic          a_vld,
    input  logic [PW-1:0] a_dest,
    input  logic [DW-1:0] a_data,
    input  logic          a_err,
    input  logic [PW-1:0] a_err_pos,
    input  logic          b_vld,
    input  logic [PW-1:0] b_dest,
    input  logic [DW-1:0] b_data,
    input  logic          b_err,
    input  logic [PW-1:0] b_err_pos,
    output logic [N-1:0]  dlv_valid,
    output logic [N*DW-1:0] dlv_data,
    output logic [N-1:0]  inj_err
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_pos
            localparam logic [PW-1:0] POS = PW'(i);
            logic hit_a, hit_b;
            // Decode of both segment stages for this position
            always_comb begin
                hit_a        = a_vld && (a_dest == POS);
                hit_b        = b_vld && (b_dest == POS);
                dlv_valid[i] = hit_a || hit_b;
                dlv_data[i*DW +: DW] = hit_a ? a_data : (hit_b ? b_data : '0);
                inj_err[i]   = (a_err && (a_err_pos == POS))
                               || (b_err && (b_err_pos == POS));
            end
        end
    endgenerate
endmodule

// File: rtl/mdx_channel.sv
// mdx_channel: top of the split multi-drop express channel. It contains the
// lower and upper segments, the reconfiguration controller and the output
// fan-out. Assumes N_POS is at least 2.
module mdx_channel #(
    parameter int N_POS  = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_POS-1:0]      inj_valid,
    input  logic [N_POS*3-1:0]    inj_dest,
    input  logic [N_POS*DATA_W-1:0] inj_data,
    input  logic                  cfg_req,
    input  logic                  cfg_split,
    input  logic [2:0]            cfg_point,
    input  logic [2:0]            cfg_src_lo,
    input  logic [2:0]            cfg_src_hi,
    output logic                  cfg_done,
    output logic                  drained,
    output logic [N_POS-1:0]      dlv_valid,
    output logic [N_POS*DATA_W-1:0] dlv_data,
    output logic [N_POS-1:0]      inj_err
);
    localparam int PW = 3;
    localparam int CW = 2;

    logic          run;
    logic          acc_a, acc_b;
    logic          seg_a_vld, seg_b_vld, err_a, err_b;
    logic [PW-1:0] dest_a, dest_b, epos_a, epos_b;
    logic [DATA_W-1:0] data_a, data_b;
    logic          act_split;
    logic [PW-1:0] act_point, act_src_lo, act_src_hi;

    mdx_cfg_ctrl #(.PW(PW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req),
        .req_split(cfg_split), .req_point(cfg_point),
        .req_src_lo(cfg_src_lo), .req_src_hi(cfg_src_hi),
        .acc_a(acc_a), .dlv_a(seg_a_vld), .acc_b(acc_b), .dlv_b(seg_b_vld),
        .run(run), .drained(drained), .cfg_done(cfg_done),
        .act_split(act_split), .act_point(act_point),
        .act_src_lo(act_src_lo), .act_src_hi(act_src_hi)
    );

    mdx_segment #(.N(N_POS), .PW(PW), .DW(DATA_W), .UPPER(1'b0)) u_seg_a (
        .clk(clk), .rst_n(rst_n), .run(run), .split(act_split),
        .point(act_point), .src(act_src_lo), .inj_valid(inj_valid),
        .inj_dest(inj_dest), .inj_data(inj_data), .accept(acc_a),
        .q_vld(seg_a_vld), .q_dest(dest_a), .q_data(data_a),
        .err_vld(err_a), .err_pos(epos_a)
    );

    mdx_segment #(.N(N_POS), .PW(PW), .DW(DATA_W), .UPPER(1'b1)) u_seg_b (
        .clk(clk), .rst_n(rst_n), .run(run), .split(act_split),
        .point(act_point), .src(act_src_hi), .inj_valid(inj_valid),
        .inj_dest(inj_dest), .inj_data(inj_data), .accept(acc_b),
        .q_vld(seg_b_vld), .q_dest(dest_b), .q_data(data_b),
        .err_vld(err_b), .err_pos(epos_b)
    );

    mdx_drop_fanout #(.N(N_POS), .PW(PW), .DW(DATA_W)) u_fan (
        .a_vld(seg_a_vld), .a_dest(dest_a), .a_data(data_a),
        .a_err(err_a), .a_err_pos(epos_a),
        .b_vld(seg_b_vld), .b_dest(dest_b), .b_data(data_b),
        .b_err(err_b), .b_err_pos(epos_b),
        .dlv_valid(dlv_valid), .dlv_data(dlv_data), .inj_err(inj_err)
    );
endmodule

// File: rtl/mdx_channel_chk.sv
// mdx_channel_chk: cycle-level properties of the channel, bound to the top.
module mdx_channel_chk #(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          acc_a,
    input logic          acc_b,
    input logic          seg_a_vld,
    input logic          seg_b_vld,
    input logic          cfg_done,
    input logic          drained,
    input logic [N-1:0]  dlv_valid,
    input logic [N-1:0]  inj_err,
    input logic [N-1:0]  inj_valid,
    input logic [PW-1:0] act_src_lo,
    input logic [PW-1:0] act_src_hi
);
    AST_ONE_HOP_A: assert property (@(posedge clk) disable iff (!rst_n) acc_a |=> seg_a_vld); // R3
    AST_ONE_HOP_B: assert property (@(posedge clk) disable iff (!rst_n) acc_b |=> seg_b_vld); // R3
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) !run |-> (!acc_a && !acc_b)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cfg_done |=> !cfg_done); // R8
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) cfg_done |-> drained); // R9
    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (seg_a_vld || seg_b_vld) |-> !drained); // R9
    AST_TWO_DROPS: assert property (@(posedge clk) disable iff (!rst_n) $countones(dlv_valid) <= 2); // R6
    AST_TWO_ERRS: assert property (@(posedge clk) disable iff (!rst_n) $countones(inj_err) <= 2); // R7
    AST_SRC_ONLY_A: assert property (@(posedge clk) disable iff (!rst_n) acc_a |-> inj_valid[act_src_lo]); // R2
    AST_SRC_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n) acc_b |-> inj_valid[act_src_hi]); // R2
endmodule

bind mdx_channel mdx_channel_chk #(.N(N_POS), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .acc_a(acc_a), .acc_b(acc_b),
    .seg_a_vld(seg_a_vld), .seg_b_vld(seg_b_vld), .cfg_done(cfg_done),
    .drained(drained), .dlv_valid(dlv_valid), .inj_err(inj_err),
    .inj_valid(inj_valid), .act_src_lo(act_src_lo), .act_src_hi(act_src_hi)
);

// File: tb/sim_mdx_channel.sv
// Directed bench for mdx_channel: one task per scenario.
module sim_mdx_channel;
    localparam int N  = 8;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    inj_valid = '0;
    logic [N*3-1:0]  inj_dest = '0;
    logic [N*DW-1:0] inj_data = '0;
    logic            cfg_req = 1'b0, cfg_split = 1'b0;
    logic [2:0]      cfg_point = '0, cfg_src_lo = '0, cfg_src_hi = '0;
    logic            cfg_done, drained;
    logic [N-1:0]    dlv_valid, inj_err;
    logic [N*DW-1:0] dlv_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mdx_channel #(.N_POS(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_dest(inj_dest),
        .inj_data(inj_data), .cfg_req(cfg_req), .cfg_split(cfg_split),
        .cfg_point(cfg_point), .cfg_src_lo(cfg_src_lo), .cfg_src_hi(cfg_src_hi),
        .cfg_done(cfg_done), .drained(drained), .dlv_valid(dlv_valid),
        .dlv_data(dlv_data), .inj_err(inj_err)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic offer(int pos, int dest, logic [DW-1:0] d);
        inj_valid[pos]          = 1'b1;
        inj_dest[pos*3 +: 3]    = 3'(dest);
        inj_data[pos*DW +: DW]  = d;
    endtask

    task automatic clear_offers();
        inj_valid = '0;
        inj_dest  = '0;
        inj_data  = '0;
    endtask

    // Apply settings while idle; checks the acknowledge timing
    task automatic do_cfg(bit sp, int pt, int lo, int hi);
        cfg_req = 1'b1; cfg_split = sp; cfg_point = 3'(pt);
        cfg_src_lo = 3'(lo); cfg_src_hi = 3'(hi);
        @(negedge clk);
        cfg_req = 1'b0;
        @(negedge clk);
        chk("R8 done pulse", 64'(cfg_done), 64'd1);
        @(negedge clk);
        chk("R8 done single", 64'(cfg_done), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 no delivery", 64'(dlv_valid), 64'd0);
        chk("R1 no error", 64'(inj_err), 64'd0);
        chk("R1 drained", 64'(drained), 64'd1);
        chk("R1 done low", 64'(cfg_done), 64'd0);
    endtask

    task automatic t_basic();
        offer(0, 7, 32'hA5A5_0007);
        @(negedge clk);
        clear_offers();
        chk("R1 R3 far drop", 64'(dlv_valid), 64'h80);
        chk("R3 data", 64'(dlv_data[7*DW +: DW]), 64'hA5A5_0007);
        @(negedge clk);
        chk("R3 single cycle", 64'(dlv_valid), 64'd0);
    endtask

    task automatic t_nonsource();
        offer(3, 5, 32'h3333);
        @(negedge clk);
        clear_offers();
        chk("R2 non-source drop", 64'(dlv_valid), 64'd0);
        chk("R2 non-source err", 64'(inj_err), 64'd0);
    endtask

    task automatic t_reverse();
        do_cfg(1'b0, 0, 5, 0);
        offer(5, 2, 32'h0502);
        @(negedge clk);
        clear_offers();
        chk("R4 downward", 64'(dlv_valid), 64'h04);
        chk("R4 data", 64'(dlv_data[2*DW +: DW]), 64'h0502);
        offer(5, 7, 32'h0507);
        @(negedge clk);
        clear_offers();
        chk("R4 upward", 64'(dlv_valid), 64'h80);
    endtask

    task automatic t_split();
        do_cfg(1'b1, 3, 1, 6);
        offer(1, 3, 32'h1103);
        offer(6, 4, 32'h6604);
        @(negedge clk);
        clear_offers();
        chk("R6 two drops", 64'(dlv_valid), 64'h18);
        chk("R6 data lo", 64'(dlv_data[3*DW +: DW]), 64'h1103);
        chk("R6 data hi", 64'(dlv_data[4*DW +: DW]), 64'h6604);
    endtask

    task automatic t_error();
        offer(6, 2, 32'hBAD);
        @(negedge clk);
        clear_offers();
        chk("R7 outside err", 64'(inj_err), 64'h40);
        chk("R7 outside no drop", 64'(dlv_valid), 64'd0);
        offer(1, 1, 32'hBAD);
        @(negedge clk);
        clear_offers();
        chk("R7 self err", 64'(inj_err), 64'h02);
        @(negedge clk);
        chk("R7 err pulse", 64'(inj_err), 64'd0);
    endtask

    task automatic t_idle_seg();
        do_cfg(1'b1, 3, 0, 2);
        offer(2, 5, 32'h25);
        @(negedge clk);
        clear_offers();
        chk("R10 idle drop", 64'(dlv_valid), 64'd0);
        chk("R10 idle err", 64'(inj_err), 64'd0);
        offer(0, 3, 32'h03);
        @(negedge clk);
        clear_offers();
        chk("R5 lower edge", 64'(dlv_valid), 64'h08);
        offer(0, 4, 32'h04);
        @(negedge clk);
        clear_offers();
        chk("R5 past split err", 64'(inj_err), 64'h01);
    endtask

    task automatic t_top_split();
        do_cfg(1'b1, 7, 0, 7);
        offer(0, 7, 32'h77);
        @(negedge clk);
        clear_offers();
        chk("R5 full lower", 64'(dlv_valid), 64'h80);
        offer(7, 0, 32'h70);
        @(negedge clk);
        clear_offers();
        chk("R10 empty upper", 64'(dlv_valid | inj_err), 64'd0);
    endtask

    task automatic t_drain();
        do_cfg(1'b1, 3, 1, 6);
        cfg_req = 1'b1; cfg_split = 1'b0; cfg_point = 3'd0;
        cfg_src_lo = 3'd4; cfg_src_hi = 3'd0;
        offer(1, 0, 32'hD0);
        @(negedge clk);
        cfg_req = 1'b0;
        chk("R3 last flit", 64'(dlv_valid), 64'h01);
        chk("R9 busy", 64'(drained), 64'd0);
        chk("R8 not yet", 64'(cfg_done), 64'd0);
        @(negedge clk);
        clear_offers();
        chk("R8 blocked", 64'(dlv_valid | inj_err), 64'd0);
        chk("R9 empty", 64'(drained), 64'd1);
        chk("R8 still waiting", 64'(cfg_done), 64'd0);
        @(negedge clk);
        chk("R8 commit", 64'(cfg_done), 64'd1);
        offer(1, 0, 32'hD1);
        @(negedge clk);
        clear_offers();
        chk("R8 old source off", 64'(dlv_valid | inj_err), 64'd0);
        offer(4, 0, 32'hD4);
        @(negedge clk);
        clear_offers();
        chk("R8 new source", 64'(dlv_valid), 64'h01);
        chk("R8 new data", 64'(dlv_data[0 +: DW]), 64'hD4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nonsource();
        t_reverse();
        t_split();
        t_error();
        t_idle_seg();
        t_top_split();
        t_drain();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule